// File: doc/BRIEF.md
# Multi-Channel Timer Interrupt Aggregator

This block collects hardware events from a group of timer channels and turns them into one interrupt request per channel. Each channel owns four interrupt sources, named A, B, C and D, and each source has a pending flag and an enable flag. Each channel reports its current operating mode: dual 8-bit PWM, single 16-bit PWM, capture, or off. The mode selects which of the channel's raw timer events drives each of its four pending flags.

Software clears pending flags by writing ones to the pending register (write-one-to-clear). It loads the enable register with a full-word write. A channel that is in low-power mode holds its pending flags: clear writes that target it are accepted but have no effect. A channel's request is a registered output that follows the OR of its enabled pending flags. The timers that generate the events lie outside this block.

Top module: `tmr_irq_agg`

## Requirements
- R1: The flag index of channel c, source s (A=0, B=1, C=2, D=3) is c*4+s. While rst_ni is low, pend_o, en_o and irq_o are all zero.
- R2: irq_o[c] is registered. After each clock edge it equals the OR of (pend_o & en_o) over bits c*4..c*4+3. It therefore falls on the edge that clears the channel's last enabled pending flag.
- R3: Mode 2'b00 (dual 8-bit PWM) maps the events as follows: A is set by event bit 0 (low-byte duty match), B by bit 1 (low-byte period match), C by bit 2 (high-byte duty match) and D by bit 3 (high-byte period match). Event bit b of channel c is tmr_evt_i[c*9+b], and the mode of channel c is ch_mode_i[c*2+:2].
- R4: Mode 2'b01 (16-bit PWM) maps the events as follows: A is set by event bit 4 (duty match) and B by bit 5 (period match). C and D are never set.
- R5: Mode 2'b10 (capture) maps the events as follows: A is set by bit 6 (capture into period), B by bit 7 (capture into duty) and C by bit 8 (counter overflow). D is never set. Mode 2'b11 sets no flag.
- R6: A cycle with wr_en_i=1 and wr_sel_i=0 clears every pending flag whose wr_data_i bit is 1. Flags whose bit is 0 are unchanged.
- R7: While ch_lowpwr_i[c] is 1, clear writes leave all four pending flags of channel c unchanged.
- R8: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: A cycle with wr_en_i=1 and wr_sel_i=1 loads en_o with wr_data_i at the next edge. Writes of the other kind never change en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_mode_i | input | 8 | Two-bit mode of each channel |
| ch_lowpwr_i | input | 4 | Low-power state of each channel |
| tmr_evt_i | input | 36 | Nine raw event bits per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects pending clear, 1 selects enable load |
| wr_data_i | input | 16 | Write data, one bit per source |
| pend_o | output | 16 | Pending flags |
| en_o | output | 16 | Enable flags |
| irq_o | output | 4 | One interrupt request per channel |

## Verification
Every result is due exactly one edge after its stimulus: an event, a clear, or an enable write in cycle k shows on pend_o, en_o and irq_o after the clock edge that ends cycle k. irq_o is computed from the next-state flags, so it changes on the same edge as the flags. The bench drives inputs on the falling edge and samples the outputs on the following falling edge. It compares them against a model that applies that cycle's stimulus to its own copy of the flags. Directed steps cover each mode mapping, low-power clear blocking and set-versus-clear collisions before a long random phase.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

  localparam int unsigned SRC_N = 4;
  localparam int unsigned EVT_W = 9;

  typedef enum logic [1:0] {
    MODE_PWM8  = 2'b00,
    MODE_PWM16 = 2'b01,
    MODE_CAPT  = 2'b10,
    MODE_OFF   = 2'b11
  } ch_mode_e;

  // raw event bit positions inside one channel's event field
  localparam int unsigned EV_DUTY_LO = 0;
  localparam int unsigned EV_PER_LO  = 1;
  localparam int unsigned EV_DUTY_HI = 2;
  localparam int unsigned EV_PER_HI  = 3;
  localparam int unsigned EV_DUTY16  = 4;
  localparam int unsigned EV_PER16   = 5;
  localparam int unsigned EV_CAP_PER = 6;
  localparam int unsigned EV_CAP_DTY = 7;
  localparam int unsigned EV_OVF     = 8;

  // returns the per-source set vector {D, C, B, A}
  function automatic logic [SRC_N-1:0] map_events(input ch_mode_e mode,
                                                  input logic [EVT_W-1:0] ev);
    logic [SRC_N-1:0] s;
    s = '0;
    unique case (mode)
      MODE_PWM8: begin
        s[0] = ev[EV_DUTY_LO];
        s[1] = ev[EV_PER_LO];
        s[2] = ev[EV_DUTY_HI];
        s[3] = ev[EV_PER_HI];
      end
      MODE_PWM16: begin
        s[0] = ev[EV_DUTY16];
        s[1] = ev[EV_PER16];
      end
      MODE_CAPT: begin
        s[0] = ev[EV_CAP_PER];
        s[1] = ev[EV_CAP_DTY];
        s[2] = ev[EV_OVF];
      end
      default: s = '0;
    endcase
    return s;
  endfunction

  // next value of one flag group: set dominates clear
  function automatic logic [SRC_N-1:0] flag_next(input logic [SRC_N-1:0] cur,
                                                 input logic [SRC_N-1:0] set,
                                                 input logic [SRC_N-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/tirq_src_map.sv
module tirq_src_map
  import tirq_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [SRC_N-1:0] set_o
);

  always_comb begin
    set_o = map_events(ch_mode_e'(mode_i), evt_i);
  end

endmodule

// File: rtl/tirq_flag_bank.sv
module tirq_flag_bank
  import tirq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lowpwr_i,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_req_i,
  input  logic             en_we_i,
  input  logic [SRC_N-1:0] en_data_i,
  output logic [SRC_N-1:0] clr_eff_o,
  output logic [SRC_N-1:0] pend_o,
  output logic [SRC_N-1:0] en_o,
  output logic [SRC_N-1:0] pend_nxt_o,
  output logic [SRC_N-1:0] en_nxt_o
);

  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] en_q;

  always_comb begin
    clr_eff_o  = lowpwr_i ? '0 : clr_req_i;
    pend_nxt_o = flag_next(pend_q, set_i, clr_eff_o);
    en_nxt_o   = en_we_i ? en_data_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_nxt_o;
      en_q   <= en_nxt_o;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/tirq_req_reg.sv
module tirq_req_reg
  import tirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*SRC_N-1:0] pend_nxt_i,
  input  logic [NUM_CH*SRC_N-1:0] en_nxt_i,
  output logic [NUM_CH-1:0]       irq_o
);

  logic [NUM_CH-1:0] any_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_any
    assign any_w[c] = |(pend_nxt_i[c*SRC_N +: SRC_N] & en_nxt_i[c*SRC_N +: SRC_N]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= any_w;
  end

endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg
  import tirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned FLAG_W = NUM_CH * SRC_N
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2*NUM_CH-1:0]     ch_mode_i,
  input  logic [NUM_CH-1:0]       ch_lowpwr_i,
  input  logic [NUM_CH*EVT_W-1:0] tmr_evt_i,
  input  logic                    wr_en_i,
  input  logic                    wr_sel_i,
  input  logic [FLAG_W-1:0]       wr_data_i,
  output logic [FLAG_W-1:0]       pend_o,
  output logic [FLAG_W-1:0]       en_o,
  output logic [NUM_CH-1:0]       irq_o
);

  // named internal events, observed by the bound checker
  logic [FLAG_W-1:0] set_w;
  logic [FLAG_W-1:0] clr_req_w;
  logic [FLAG_W-1:0] clr_w;
  logic [FLAG_W-1:0] pend_nxt_w;
  logic [FLAG_W-1:0] en_nxt_w;
  logic              clr_wr_w;
  logic              en_wr_w;

  assign clr_wr_w  = wr_en_i & ~wr_sel_i;
  assign en_wr_w   = wr_en_i &  wr_sel_i;
  assign clr_req_w = clr_wr_w ? wr_data_i : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tirq_src_map u_map (
      .mode_i (ch_mode_i[c*2 +: 2]),
      .evt_i  (tmr_evt_i[c*EVT_W +: EVT_W]),
      .set_o  (set_w[c*SRC_N +: SRC_N])
    );

    tirq_flag_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lowpwr_i   (ch_lowpwr_i[c]),
      .set_i      (set_w[c*SRC_N +: SRC_N]),
      .clr_req_i  (clr_req_w[c*SRC_N +: SRC_N]),
      .en_we_i    (en_wr_w),
      .en_data_i  (wr_data_i[c*SRC_N +: SRC_N]),
      .clr_eff_o  (clr_w[c*SRC_N +: SRC_N]),
      .pend_o     (pend_o[c*SRC_N +: SRC_N]),
      .en_o       (en_o[c*SRC_N +: SRC_N]),
      .pend_nxt_o (pend_nxt_w[c*SRC_N +: SRC_N]),
      .en_nxt_o   (en_nxt_w[c*SRC_N +: SRC_N])
    );
  end

  tirq_req_reg #(.NUM_CH(NUM_CH)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_nxt_i (pend_nxt_w),
    .en_nxt_i   (en_nxt_w),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/tirq_chk.sv
module tirq_chk
  import tirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned FLAG_W = NUM_CH * SRC_N
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*NUM_CH-1:0] ch_mode_i,
  input logic [NUM_CH-1:0]   ch_lowpwr_i,
  input logic                wr_en_i,
  input logic                wr_sel_i,
  input logic [FLAG_W-1:0]   wr_data_i,
  input logic [FLAG_W-1:0]   pend_o,
  input logic [FLAG_W-1:0]   en_o,
  input logic [NUM_CH-1:0]   irq_o,
  input logic [FLAG_W-1:0]   set_w,
  input logic [FLAG_W-1:0]   clr_w
);

  // R9: enable register loads the written word one edge later
  p_en_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (en_o == $past(wr_data_i)));

  // R9: pending-clear writes and idle cycles never touch enables
  p_en_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i) |=> $stable(en_o));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R2: request follows enabled pending flags after every edge
    p_irq_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] == |(pend_o[c*SRC_N +: SRC_N] & en_o[c*SRC_N +: SRC_N]));

    // R4: 16-bit PWM never raises C or D
    p_pwm16_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_mode_i[c*2 +: 2] == 2'b01 && pend_o[c*SRC_N+2 +: 2] == 2'b00)
      |=> (pend_o[c*SRC_N+2 +: 2] == 2'b00));

    // R5: capture never raises D
    p_capt_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_mode_i[c*2 +: 2] == 2'b10 && !pend_o[c*SRC_N+3])
      |=> !pend_o[c*SRC_N+3]);

    // R7: low-power channel gets no effective clears
    p_lp_noclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_lowpwr_i[c] |-> (clr_w[c*SRC_N +: SRC_N] == '0));

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
      // R7: a held flag survives any write while in low power
      p_lp_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ch_lowpwr_i[c] && pend_o[c*SRC_N+s]) |=> pend_o[c*SRC_N+s]);

      // R8: a hardware set always lands
      p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_w[c*SRC_N+s] |=> pend_o[c*SRC_N+s]);

      // R6: one-bit clear without a competing set empties the flag
      p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_sel_i && wr_data_i[c*SRC_N+s] && !ch_lowpwr_i[c]
         && !set_w[c*SRC_N+s]) |=> !pend_o[c*SRC_N+s]);
    end
  end

endmodule

bind tmr_irq_agg tirq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ch_mode_i   (ch_mode_i),
  .ch_lowpwr_i (ch_lowpwr_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .pend_o      (pend_o),
  .en_o        (en_o),
  .irq_o       (irq_o),
  .set_w       (set_w),
  .clr_w       (clr_w)
);

// File: tb/tmr_irq_agg_tb_top.sv
module tmr_irq_agg_tb_top;

  localparam int NCH = 4;
  localparam int FW  = NCH * 4;
  localparam int EW  = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2*NCH-1:0] mode = '0;
  logic [NCH-1:0]  lp = '0;
  logic [NCH*EW-1:0] evt = '0;
  logic            wen = 1'b0;
  logic            wsel = 1'b0;
  logic [FW-1:0]   wdat = '0;
  logic [FW-1:0]   pend;
  logic [FW-1:0]   en;
  logic [NCH-1:0]  irq;

  logic [FW-1:0]   m_pend = '0;
  logic [FW-1:0]   m_en = '0;
  logic [NCH-1:0]  m_irq = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_irq_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ch_mode_i(mode), .ch_lowpwr_i(lp),
    .tmr_evt_i(evt), .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdat),
    .pend_o(pend), .en_o(en), .irq_o(irq)
  );

  // bench view of the mode table: returns {D,C,B,A}
  function automatic logic [3:0] exp_set(input logic [1:0] md, input logic [8:0] e);
    if (md == 2'b00) return e[3:0];
    if (md == 2'b01) return {2'b00, e[5], e[4]};
    if (md == 2'b10) return {1'b0, e[8:6]};
    return 4'b0000;
  endfunction

  task automatic chk(input logic [FW-1:0] act, input logic [FW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply inputs at a falling edge, advance the model, wait one cycle
  task automatic step(input logic [2*NCH-1:0] md, input logic [NCH-1:0] l,
                      input logic [NCH*EW-1:0] e, input logic we, input logic ws,
                      input logic [FW-1:0] wd);
    mode = md; lp = l; evt = e; wen = we; wsel = ws; wdat = wd;
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 4; s++) begin
        logic st, cl;
        st = exp_set(md[c*2 +: 2], e[c*EW +: EW])[s];
        cl = we && !ws && wd[c*4+s] && !l[c];
        if (st) m_pend[c*4+s] = 1'b1;
        else if (cl) m_pend[c*4+s] = 1'b0;
      end
    end
    if (we && ws) m_en = wd;
    for (int c = 0; c < NCH; c++) m_irq[c] = |(m_pend[c*4 +: 4] & m_en[c*4 +: 4]);
    @(negedge clk);
  endtask

  task automatic check_all(input string tp, input string te, input string ti);
    chk(pend, m_pend, tp);
    chk(en, m_en, te);
    chk({12'h0, irq}, {12'h0, m_irq}, ti);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check_all("R1 reset pend", "R1 reset en", "R1 reset irq");
    rst_n = 1'b1;
    @(negedge clk);

    // R3: dual 8-bit mapping on channel 0
    step(8'b11_10_01_00, 4'h0, 36'h0_0000_0001, 1'b0, 1'b0, '0);
    chk(pend, 16'h0001, "R3 low duty -> A");
    step(8'b11_10_01_00, 4'h0, 36'h0_0000_0008, 1'b0, 1'b0, '0);
    chk(pend, 16'h0009, "R3 high period -> D");
    step(8'b11_10_01_00, 4'h0, 36'h0_0000_0006, 1'b0, 1'b0, '0);
    chk(pend, 16'h000F, "R3 B and C");
    // R4: 16-bit PWM, every event bit of channel 1 active
    step(8'b11_10_01_00, 4'h0, {9'h0, 9'h0, 9'h1FF, 9'h0}, 1'b0, 1'b0, '0);
    chk(pend, 16'h003F, "R4 only A and B");
    // R5: capture on channel 2, off on channel 3
    step(8'b11_10_01_00, 4'h0, {9'h1FF, 9'h1FF, 9'h0, 9'h0}, 1'b0, 1'b0, '0);
    chk(pend, 16'h073F, "R5 capture A B C, off none");
    // R9 / R2: enable everything
    step(8'b11_10_01_00, 4'h0, '0, 1'b1, 1'b1, 16'hFFFF);
    check_all("R9 pend kept", "R9 enable load", "R2 irq after enable");
    // R6: clear bit 0, keep bit 3
    step(8'b11_10_01_00, 4'h0, '0, 1'b1, 1'b0, 16'h0001);
    chk(pend, 16'h073E, "R6 w1c partial");
    chk(en, 16'hFFFF, "R9 clear write leaves enables");
    // R7: channel 1 low power, clear its flags
    step(8'b11_10_01_00, 4'h2, '0, 1'b1, 1'b0, 16'h00F0);
    chk(pend, 16'h073E, "R7 low power holds");
    // R8: set and clear of flag 3 together
    step(8'b11_10_01_00, 4'h0, 36'h0_0000_0008, 1'b1, 1'b0, 16'h0008);
    chk(pend, 16'h073E, "R8 set beats clear");
    // R2: clear all, requests drop
    step(8'b11_10_01_00, 4'h0, '0, 1'b1, 1'b0, 16'hFFFF);
    check_all("R6 clear all", "R9 en steady", "R2 irq drop");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [NCH*EW-1:0] e;
      logic [2*NCH-1:0] md;
      md = (i % 37 == 0) ? 8'($urandom) : mode;
      e = '0;
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 3) == 0) e[c*EW +: EW] = 9'($urandom);
      step(md, 4'($urandom), e, ($urandom_range(0, 2) == 0), 1'($urandom),
           16'($urandom));
      check_all("R1 random pend", "R9 random en", "R2 random irq");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule